// File: doc/BRIEF.md
# UART Receiver with Receive FIFO and Flow Control

This block receives asynchronous serial frames on one input line and stores the received bytes in a 16-entry receive FIFO. Software drains the FIFO through a read port. A frame is a low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one high stop bit. The line rests high between frames. Bit timing comes only from an enable pulse that arrives sixteen times per bit period. The block passes the line through a two-flop synchronizer. It confirms the start bit halfway into the bit and then samples each later bit at its centre.

Four sticky status flags report the receiver state: data-ready, framing error, parity error and overrun. The data-ready flag drives the receive interrupt. It is set while the FIFO holds at least a chosen number of bytes (1, 4, 8 or 14). Framing and parity errors drive a separate error interrupt. Software clears a flag in two steps. It first reads the status while the flag is 1, which arms the flag. A later write of zero to that flag then clears it. When flow control is on, the request-to-send output goes high while the FIFO is full.

Top module: `uart_rx_fifo`

## Requirements
- R1: A falling edge on the synchronized line starts a frame only if the line is still low when the 8th oversample tick after detection arrives. A low pulse that is shorter than this is ignored and stores nothing.
- R2: The eight data bits are assembled least significant bit first. Each complete frame pushes its byte into the FIFO, whether or not it had a parity or framing error, unless the FIFO is full.
- R3: With `parity_en`=1, a parity bit follows bit 7. `parity_odd`=0 selects even parity and `parity_odd`=1 selects odd parity. A mismatch sets `flags[2]`, which raises `err_irq`. With `parity_en`=0, the frame has no parity bit and `flags[2]` is not set.
- R4: A stop bit sampled as 0 sets `flags[1]` (framing error), which raises `err_irq`.
- R5: The FIFO holds 16 bytes in arrival order. `rd_data` shows the oldest byte. `rd_en` removes it when `rx_count` is nonzero. `rx_count` never exceeds 16.
- R6: `flags[0]` (data-ready) is set in the cycle after `rx_count` is at or above the trigger level. The trigger level is selected by `trig_sel`: 0→1, 1→4, 2→8, 3→14. `rx_irq` equals `flags[0]`.
- R7: A write with `clr_wr`=1 clears each flag whose `clr_mask` bit is 1 (bit 0 data-ready, 1 framing, 2 parity, 3 overrun). The clear takes effect only if a `status_rd` pulse saw that flag as 1 since the last clear. Otherwise the write has no effect. A set condition in the same cycle wins over the clear.
- R8: A frame that completes while the FIFO is full is discarded, and the FIFO contents and `rx_count` are unchanged. The frame sets `flags[3]` (overrun), which stays set until it is cleared as in R7. Overrun alone does not raise `err_irq`.
- R9: `rts_out` is 1 exactly when `flow_en`=1 and the FIFO holds 16 bytes, and 0 otherwise.
- R10: The receiver state advances only on cycles with `tick_en`=1, so the bit period is 16 ticks whatever the tick rate is.
- R11: After reset, `rx_count`=0, all flags are 0, both interrupts are 0 and `rts_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Oversample enable, 16 pulses per bit |
| rxd_in | input | 1 | Serial receive line, idles high |
| parity_en | input | 1 | 1 = frame carries a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| flow_en | input | 1 | 1 = drive `rts_out` from the FIFO full state |
| trig_sel | input | 2 | Data-ready trigger level select |
| rd_en | input | 1 | Pop the oldest FIFO byte |
| rd_data | output | 8 | Oldest FIFO byte |
| rx_count | output | 5 | Number of bytes held |
| status_rd | input | 1 | Status read strobe; arms the flags that read as 1 |
| clr_wr | input | 1 | Write-zero strobe for flags |
| clr_mask | input | 4 | Flags targeted by the write-zero |
| flags | output | 4 | {overrun, parity error, framing error, data-ready} |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| rts_out | output | 1 | Request-to-send, 1 = stop sending |

## Verification
The table of frames covers each parity setting combined with good and corrupted parity and stop bits. These cases separate correct bit ordering, the even/odd sense, and which error flag fires for each fault. A run of sixteen counting bytes fills the FIFO. It shows the trigger threshold at 4, the request-to-send edge at exactly the sixteenth entry, and that a seventeenth frame only marks overrun. The later drain confirms order and that nothing was overwritten. Further directed cases use a short low glitch to separate a real start from noise. A halved tick rate confirms that timing follows the enable and not the clock. A write-zero without a preceding status read shows that an unarmed clear does nothing.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_en,
  input  logic                     rxd_in,
  input  logic                     parity_en,
  input  logic                     parity_odd,
  input  logic                     flow_en,
  input  logic [1:0]               trig_sel,
  input  logic                     rd_en,
  output logic [7:0]               rd_data,
  output logic [$clog2(DEPTH):0]   rx_count,
  input  logic                     status_rd,
  input  logic                     clr_wr,
  input  logic [3:0]               clr_mask,
  output logic [3:0]               flags,
  output logic                     rx_irq,
  output logic                     err_irq,
  output logic                     rts_out
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0]    sync_q;
  logic          rx_s;
  st_t           st_q;
  logic [CW-1:0] os_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          par_q;
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic [3:0]    flag_q, armed_q;
  logic [AW:0]   trig_lvl;
  logic          done, stop_bad, par_bad, full, push, pop;
  logic [3:0]    set_v;

  assign rx_s     = sync_q[1];
  assign done     = tick_en && st_q == S_STOP && os_q == LAST;
  assign stop_bad = !rx_s;
  assign par_bad  = parity_en && ((^{sh_q, par_q}) ^ parity_odd);
  assign full     = cnt_q == (AW+1)'(DEPTH);
  assign push     = done && !full;
  assign pop      = rd_en && cnt_q != '0;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = (AW+1)'(1);
      2'd1:    trig_lvl = (AW+1)'(4);
      2'd2:    trig_lvl = (AW+1)'(8);
      default: trig_lvl = (AW+1)'(14);
    endcase
  end

  assign set_v    = {done && full, done && par_bad, done && stop_bad, cnt_q >= trig_lvl};
  assign rd_data  = mem_q[rp_q];
  assign rx_count = cnt_q;
  assign flags    = flag_q;
  assign rx_irq   = flag_q[0];
  assign err_irq  = flag_q[1] | flag_q[2];
  assign rts_out  = flow_en && full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      os_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else if (tick_en) begin
      os_q <= os_q + 1'b1;
      case (st_q)
        S_IDLE: begin
          os_q <= '0;
          if (!rx_s) st_q <= S_START;
        end
        S_START: if (os_q == MID) begin
          os_q  <= '0;
          bit_q <= '0;
          st_q  <= rx_s ? S_IDLE : S_DATA;
        end
        S_DATA: if (os_q == LAST) begin
          sh_q  <= {rx_s, sh_q[7:1]};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 3'd7) st_q <= parity_en ? S_PAR : S_STOP;
        end
        S_PAR: if (os_q == LAST) begin
          par_q <= rx_s;
          st_q  <= S_STOP;
        end
        default: if (os_q == LAST) st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) if (push) mem_q[wp_q] <= sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      armed_q <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        flag_q[i] <= set_v[i] | (flag_q[i] & !(clr_wr && clr_mask[i] && armed_q[i]));
        if (clr_wr && clr_mask[i])          armed_q[i] <= 1'b0;
        else if (status_rd && flag_q[i])    armed_q[i] <= 1'b1;
      end
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= (AW+1)'(DEPTH));
  a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == (AW+1)'(DEPTH) && !rd_en) |=> rx_count == (AW+1)'(DEPTH));
  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] && !(clr_wr && clr_mask[3])) |=> flags[3]);
  a_r9_rts_full: assert property (@(posedge clk) disable iff (!rst_n)
    rts_out |-> (flow_en && rx_count == (AW+1)'(DEPTH)));
  a_r6_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= trig_lvl) |=> flags[0]);
  a_r10_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(st_q));
  a_r7_clear_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(armed_q[0]));
endmodule

// File: tb/uart_rx_fifo_tb_top.sv
module uart_rx_fifo_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 8;
  // {data[13:6], parity_en, parity_odd, bad_par, bad_stop, exp_fer, exp_per}
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h7F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 0, rst_n = 0, tick_en = 1, rxd_in = 1;
  logic parity_en = 0, parity_odd = 0, flow_en = 0, rd_en = 0;
  logic status_rd = 0, clr_wr = 0;
  logic [1:0] trig_sel = 0;
  logic [3:0] clr_mask = 0;
  logic [7:0] rd_data;
  logic [4:0] rx_count;
  logic [3:0] flags;
  logic rx_irq, err_irq, rts_out;
  int checks = 0, errors = 0, div = 1, tcnt = 0, cyc = 0;
  bit done = 0;

  uart_rx_fifo dut_i (.clk, .rst_n, .tick_en, .rxd_in, .parity_en, .parity_odd,
    .flow_en, .trig_sel, .rd_en, .rd_data, .rx_count, .status_rd, .clr_wr,
    .clr_mask, .flags, .rx_irq, .err_irq, .rts_out);

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    if (tcnt >= div - 1) begin tcnt = 0; tick_en = 1; end
    else begin tcnt++; tick_en = 0; end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line(logic v);
    rxd_in = v;
    wait_n(16 * div);
  endtask

  task automatic send(logic [7:0] d, logic pe, logic odd, logic bp, logic bs);
    parity_en = pe; parity_odd = odd;
    line(1'b0);
    for (int i = 0; i < 8; i++) line(d[i]);
    if (pe) line((^d) ^ odd ^ bp);
    line(!bs);
    rxd_in = 1'b1;
    wait_n(32 * div);
  endtask

  task automatic pop();
    rd_en = 1; wait_n(1); rd_en = 0;
  endtask

  task automatic clear(logic [3:0] m, logic do_read);
    if (do_read) begin status_rd = 1; wait_n(1); status_rd = 0; end
    clr_wr = 1; clr_mask = m; wait_n(1); clr_wr = 0; clr_mask = 0;
    wait_n(1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL R10 watchdog act=%0d exp=<150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    check("R11 count", rx_count, 0);
    check("R11 flags", flags, 0);
    check("R11 irqs", {rx_irq, err_irq}, 0);
    check("R11 rts", rts_out, 0);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][13:6], VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2]);
      check("R2 data", rd_data, VEC[v][13:6]);
      check("R5 count", rx_count, 1);
      check("R4 fer", flags[1], VEC[v][1]);
      check("R3 per", flags[2], VEC[v][0]);
      check("R3 R4 err_irq", err_irq, VEC[v][1] | VEC[v][0]);
      check("R6 rx_irq", rx_irq, 1);
      pop();
      clear(4'hF, 1);
      check("R7 cleared", flags, 0);
    end

    send(8'h11, 0, 0, 0, 0);
    pop();
    clear(4'h1, 0);
    check("R7 unarmed clear ignored", flags[0], 1);
    clear(4'h1, 1);
    check("R7 armed clear", flags[0], 0);

    wait_n(1); rxd_in = 0; wait_n(3); rxd_in = 1; wait_n(60);
    check("R1 glitch ignored", rx_count, 0);
    check("R1 glitch no flags", flags, 0);

    div = 2;
    send(8'hC3, 1, 1, 0, 0);
    check("R10 slow tick data", rd_data, 8'hC3);
    check("R10 slow tick count", rx_count, 1);
    check("R10 slow tick no error", err_irq, 0);
    pop();
    div = 1;
    clear(4'hF, 1);

    trig_sel = 2'd1; flow_en = 1;
    for (int i = 0; i < 16; i++) begin
      send(8'h10 + 8'(i), 0, 0, 0, 0);
      if (i == 2)  check("R6 below trigger", rx_irq, 0);
      if (i == 3)  check("R6 at trigger", rx_irq, 1);
      if (i == 14) check("R9 rts not full", rts_out, 0);
    end
    check("R9 rts full", rts_out, 1);
    check("R5 count full", rx_count, 16);
    send(8'hEE, 0, 0, 0, 0);
    check("R8 overrun flag", flags[3], 1);
    check("R8 count unchanged", rx_count, 16);
    check("R8 head unchanged", rd_data, 8'h10);
    check("R8 no err_irq", err_irq, 0);
    flow_en = 0; wait_n(1);
    check("R9 rts off when disabled", rts_out, 0);
    flow_en = 1;
    for (int i = 0; i < 16; i++) begin
      check("R5 order", rd_data, 8'h10 + 8'(i));
      pop();
    end
    check("R5 drained", rx_count, 0);
    check("R9 rts after drain", rts_out, 0);
    check("R8 overrun sticky", flags[3], 1);
    clear(4'h8, 1);
    check("R8 overrun cleared", flags[3], 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule